// File: doc/BRIEF.md
# One-Time-Programmable System Data Boot Loader

After every reset this block walks the first 32 bytes of the system-data region of a one-time-programmable fuse array. It reads them one at a time through a byte-read port and copies each byte into a local register file. When the last byte has been stored, a done flag rises. Four configuration outputs are then decoded from the register file. Before that point they are held at zero.

Fuse cells are stored with inverted polarity. A cell that has never been programmed reads as 1, so a blank byte reads 0xFF from the array. Its register copy shows 0x00. The block also has a write path that programs one aligned 32-bit word of the region at a time. A write can only turn fuse cells from 1 to 0, which in register polarity means it can only set bits.

The fuse array is included as a behavioural model. Its contents are not cleared by reset, so programmed values reach the registers on the next reload.

Top module: `sysdata_autoload`

## Requirements
- R1: While reset is applied, and after reset until `load_done` rises, `load_done` and all four configuration outputs are 0.
- R2: After reset the block loads region bytes 0 to 31 without any request. `load_done` rises once all of them are stored and stays high until the next reset. The load takes at least one cycle per byte.
- R3: Each register byte is the bitwise inverse of the fuse byte at the same address. An unprogrammed byte therefore presents 0x00 on `reg_byte`.
- R4: The configuration outputs are decoded from the register file: `addr4b_en` = byte 2 bit 1, `nand_page_4k` = byte 2 bit 7, `log_baud_slow` = byte 3 bit 1, `boot_log_off` = byte 3 bit 0.
- R5: A write is legal only when `wr_addr[1:0]` is 0 and `wr_len` is 4. An illegal write is acknowledged with `wr_err` high and programs no fuse.
- R6: A legal write stores `wr_data` little-endian: bits 7:0 go to `wr_addr`, and bits 31:24 go to `wr_addr`+3.
- R7: `wr_data` is in register polarity. A 1 bit burns the matching fuse. Once a register bit has been set by programming, no later write can clear it.
- R8: A write requested before `load_done` is high is held. It is not acknowledged until the load has finished.
- R9: `wr_err` is sticky. It stays high across further illegal writes and is cleared when a legal write is accepted.
- R10: The register file and the configuration outputs change only during the load. A programmed value becomes visible only after the next reset.
- R11: The fuse contents persist across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts a reload |
| wr_req | input | 1 | Write request, held high until `wr_ack` |
| wr_addr | input | 5 | Region byte address of the write |
| wr_len | input | 3 | Write length in bytes |
| wr_data | input | 32 | Write data in register polarity |
| wr_ack | output | 1 | One-cycle pulse: the request has completed or been rejected |
| wr_err | output | 1 | Sticky flag set by a rejected write |
| load_done | output | 1 | Load complete |
| reg_sel | input | 5 | Register file byte select |
| reg_byte | output | 8 | Selected register byte |
| addr4b_en | output | 1 | Four-byte flash address enable |
| nand_page_4k | output | 1 | NAND page size is 4K rather than 2K |
| log_baud_slow | output | 1 | Slow log baud rate selected |
| boot_log_off | output | 1 | Boot log disabled |

## Verification
The bench aims at the polarity flip. A design that copies fuse bytes without inverting them would show 0xFF in blank registers and assert all four configuration outputs.

It also targets byte order within a word, rejection of misaligned or short words, and writes that try to clear a set bit. Swapped byte lanes would move the configuration bits to the wrong bytes. A design that accepts bad requests, or that writes a value instead of ANDing it into the fuse cells, would leave visible changes after the next reload.

Finally, it issues a write during the load, which a design without the stall acknowledges too early. It then follows with a legal write, which must clear the sticky error.

// File: rtl/sysdata_pkg.sv
package sysdata_pkg;

  // Decode positions of the configuration bits inside the register file.
  localparam int CfgByteLo   = 2;
  localparam int CfgByteHi   = 3;
  localparam int Addr4bBit   = 1;
  localparam int NandPageBit = 7;
  localparam int BaudBit     = 1;
  localparam int LogOffBit   = 0;
  localparam int WordBytes   = 4;

  typedef enum logic [1:0] {L_ISSUE, L_WAIT, L_DONE} load_st_e;
  typedef enum logic [1:0] {W_IDLE, W_PROG} wr_st_e;

  // Register view of a fuse byte: blank cells (1) present as 0.
  function automatic logic [7:0] fuse_to_reg(input logic [7:0] fuse);
    return ~fuse;
  endfunction

  // Burning: a 1 in set_bits forces the cell to 0; nothing ever returns to 1.
  function automatic logic [7:0] fuse_burn(input logic [7:0] old_val,
                                           input logic [7:0] set_bits);
    return old_val & ~set_bits;
  endfunction

  function automatic logic word_req_ok(input logic [1:0] addr_lo,
                                       input logic [2:0] len);
    return (addr_lo == 2'b00) && (len == 3'(WordBytes));
  endfunction

endpackage

// File: rtl/sysdata_fuse_array.sv
module sysdata_fuse_array #(
  parameter int OTP_BYTES = 64,
  parameter int RD_LAT    = 2,
  localparam int AW       = $clog2(OTP_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  input  logic          pg_en,
  input  logic [AW-1:0] pg_addr,
  input  logic [7:0]    pg_set
);
  import sysdata_pkg::*;

  logic [7:0] mem [OTP_BYTES];
  logic       lat_v [RD_LAT];
  logic [7:0] lat_d [RD_LAT];
  logic [7:0] prog_old;

  initial begin
    for (int i = 0; i < OTP_BYTES; i++) mem[i] = 8'hFF;
  end

  assign prog_old = mem[pg_addr];

  // Cells are not reset: they model non-volatile storage.
  always_ff @(posedge clk) begin
    if (pg_en) mem[pg_addr] <= fuse_burn(prog_old, pg_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < RD_LAT; s++) begin
        lat_v[s] <= 1'b0;
        lat_d[s] <= 8'h00;
      end
    end else begin
      lat_v[0] <= rd_en;
      lat_d[0] <= mem[rd_addr];
      for (int s = 1; s < RD_LAT; s++) begin
        lat_v[s] <= lat_v[s-1];
        lat_d[s] <= lat_d[s-1];
      end
    end
  end

  assign rd_valid = lat_v[RD_LAT-1];
  assign rd_data  = lat_d[RD_LAT-1];

  // R7: a program operation never turns a 0 cell back to 1.
  p_fuse_only_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pg_en |=> ((mem[$past(pg_addr)] & ~$past(prog_old)) == 8'h00));

endmodule

// File: rtl/sysdata_loader.sv
module sysdata_loader #(
  parameter int OTP_BYTES  = 64,
  parameter int LOAD_BYTES = 32,
  localparam int AW        = $clog2(OTP_BYTES),
  localparam int LW        = $clog2(LOAD_BYTES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic                    rd_en,
  output logic [AW-1:0]           rd_addr,
  input  logic                    rd_valid,
  input  logic [7:0]              rd_data,
  output logic                    load_done,
  output logic [LOAD_BYTES*8-1:0] regs_flat
);
  import sysdata_pkg::*;

  load_st_e   st;
  logic [LW-1:0] idx;
  logic [7:0] regs [LOAD_BYTES];
  logic       last_byte;

  assign last_byte = (idx == LW'(LOAD_BYTES - 1));
  assign rd_en     = (st == L_ISSUE);
  assign rd_addr   = AW'(idx);
  assign load_done = (st == L_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= L_ISSUE;
      idx <= '0;
      for (int i = 0; i < LOAD_BYTES; i++) regs[i] <= 8'h00;
    end else begin
      case (st)
        L_ISSUE: st <= L_WAIT;
        L_WAIT: if (rd_valid) begin
          regs[idx] <= fuse_to_reg(rd_data);
          if (last_byte) st <= L_DONE;
          else begin
            idx <= idx + 1'b1;
            st  <= L_ISSUE;
          end
        end
        default: st <= L_DONE;
      endcase
    end
  end

  for (genvar g = 0; g < LOAD_BYTES; g++) begin : g_flat
    assign regs_flat[g*8 +: 8] = regs[g];
  end

  // R2: once done, the flag stays until reset.
  p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> load_done);
  // R10: nothing touches the register file after the load.
  p_regs_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> $stable(regs_flat));
  // R2: no read is issued once the load is complete.
  p_no_read_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !rd_en);

endmodule

// File: rtl/sysdata_writer.sv
module sysdata_writer #(
  parameter int OTP_BYTES  = 64,
  parameter int LOAD_BYTES = 32,
  localparam int AW        = $clog2(OTP_BYTES),
  localparam int LW        = $clog2(LOAD_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_done,
  input  logic          wr_req,
  input  logic [LW-1:0] wr_addr,
  input  logic [2:0]    wr_len,
  input  logic [31:0]   wr_data,
  output logic          wr_ack,
  output logic          wr_err,
  output logic          pg_en,
  output logic [AW-1:0] pg_addr,
  output logic [7:0]    pg_set
);
  import sysdata_pkg::*;

  wr_st_e       st;
  logic [LW-1:0] base;
  logic [31:0]  word;
  logic [1:0]   cnt;
  logic         take, good_take, bad_take;

  assign take      = (st == W_IDLE) && wr_req && load_done && !wr_ack;
  assign good_take = take && word_req_ok(wr_addr[1:0], wr_len);
  assign bad_take  = take && !word_req_ok(wr_addr[1:0], wr_len);

  assign pg_en   = (st == W_PROG);
  assign pg_addr = AW'(base) + AW'(cnt);
  assign pg_set  = word[8*cnt +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      base   <= '0;
      word   <= '0;
      cnt    <= '0;
      wr_ack <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      wr_ack <= 1'b0;
      case (st)
        W_IDLE: begin
          if (good_take) begin
            wr_err <= 1'b0;
            base   <= wr_addr;
            word   <= wr_data;
            cnt    <= '0;
            st     <= W_PROG;
          end else if (bad_take) begin
            wr_err <= 1'b1;
            wr_ack <= 1'b1;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == 2'(WordBytes - 1)) begin
            wr_ack <= 1'b1;
            st     <= W_IDLE;
          end
        end
      endcase
    end
  end

  // R8: nothing is acknowledged before the load has finished.
  p_no_ack_before_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> !wr_ack);
  // R5: a rejected request burns nothing and raises the error.
  p_reject_no_burn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad_take |=> (!pg_en && wr_err && wr_ack));
  // R9: an accepted legal request clears the error.
  p_err_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    good_take |=> !wr_err);
  // R5: programming stays inside one aligned word.
  p_prog_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pg_en |-> (base[1:0] == 2'b00));

endmodule

// File: rtl/sysdata_autoload.sv
module sysdata_autoload #(
  parameter int OTP_BYTES  = 64,
  parameter int LOAD_BYTES = 32,
  parameter int RD_LAT     = 2,
  localparam int AW        = $clog2(OTP_BYTES),
  localparam int LW        = $clog2(LOAD_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [LW-1:0] wr_addr,
  input  logic [2:0]    wr_len,
  input  logic [31:0]   wr_data,
  output logic          wr_ack,
  output logic          wr_err,
  output logic          load_done,
  input  logic [LW-1:0] reg_sel,
  output logic [7:0]    reg_byte,
  output logic          addr4b_en,
  output logic          nand_page_4k,
  output logic          log_baud_slow,
  output logic          boot_log_off
);
  import sysdata_pkg::*;

  logic                    rd_en, rd_valid, pg_en;
  logic [AW-1:0]           rd_addr, pg_addr;
  logic [7:0]              rd_data, pg_set;
  logic [LOAD_BYTES*8-1:0] regs_flat;
  logic [7:0]              cfg_lo, cfg_hi;

  sysdata_fuse_array #(.OTP_BYTES(OTP_BYTES), .RD_LAT(RD_LAT)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .pg_en(pg_en), .pg_addr(pg_addr), .pg_set(pg_set));

  sysdata_loader #(.OTP_BYTES(OTP_BYTES), .LOAD_BYTES(LOAD_BYTES)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .load_done(load_done), .regs_flat(regs_flat));

  sysdata_writer #(.OTP_BYTES(OTP_BYTES), .LOAD_BYTES(LOAD_BYTES)) u_writer (
    .clk(clk), .rst_n(rst_n), .load_done(load_done),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
    .wr_ack(wr_ack), .wr_err(wr_err),
    .pg_en(pg_en), .pg_addr(pg_addr), .pg_set(pg_set));

  assign reg_byte = regs_flat[8*reg_sel +: 8];
  assign cfg_lo   = regs_flat[8*CfgByteLo +: 8];
  assign cfg_hi   = regs_flat[8*CfgByteHi +: 8];

  // Decoded outputs are gated until the register file is complete.
  assign addr4b_en     = load_done & cfg_lo[Addr4bBit];
  assign nand_page_4k  = load_done & cfg_lo[NandPageBit];
  assign log_baud_slow = load_done & cfg_hi[BaudBit];
  assign boot_log_off  = load_done & cfg_hi[LogOffBit];

  // R1: the configuration outputs are quiet while the load runs.
  p_cfg_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> !(addr4b_en | nand_page_4k | log_baud_slow | boot_log_off));
  // R8: no fuse is programmed before the load has finished.
  p_no_burn_in_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !pg_en);

endmodule

// File: tb/sysdata_autoload_bench.sv
module sysdata_autoload_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_req = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [2:0]  wr_len = '0;
  logic [31:0] wr_data = '0;
  logic        wr_ack, wr_err, load_done;
  logic [4:0]  reg_sel = '0;
  logic [7:0]  reg_byte;
  logic        addr4b_en, nand_page_4k, log_baud_slow, boot_log_off;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_reg [32];

  always #5 clk = ~clk;

  sysdata_autoload u_sysdata_autoload (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_len(wr_len), .wr_data(wr_data), .wr_ack(wr_ack), .wr_err(wr_err),
    .load_done(load_done), .reg_sel(reg_sel), .reg_byte(reg_byte),
    .addr4b_en(addr4b_en), .nand_page_4k(nand_page_4k),
    .log_baud_slow(log_baud_slow), .boot_log_off(boot_log_off));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!load_done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    chk(load_done, "R2 load_done timeout", {31'b0, load_done}, 1);
  endtask

  task automatic reload();
    int cyc;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!load_done && !addr4b_en && !nand_page_4k && !log_baud_slow && !boot_log_off,
        "R1 reset state", {28'b0, addr4b_en, nand_page_4k, log_baud_slow, load_done}, 0);
    rst_n = 1'b1;
    wait_done(cyc);
    chk(cyc >= 32, "R2 load length", cyc, 32);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [2:0] l,
                          input logic [31:0] d, output logic err);
    int t = 0;
    @(negedge clk);
    wr_addr = a; wr_len = l; wr_data = d; wr_req = 1'b1;
    do begin
      @(negedge clk);
      t++;
    end while (!wr_ack && t < 100);
    chk(wr_ack, "R5 write ack timeout", {31'b0, wr_ack}, 1);
    err = wr_err;
    wr_req = 1'b0;
    // bench model: legal words set bits little-endian (R6, R7)
    if (a[1:0] == 2'b00 && l == 3'd4)
      for (int k = 0; k < 4; k++) exp_reg[a + 5'(k)] |= d[8*k +: 8];
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < 32; i++) begin
      reg_sel = 5'(i);
      #1;
      chk(reg_byte == exp_reg[i], tag, reg_byte, exp_reg[i]);
    end
  endtask

  task automatic check_cfg(input string tag);
    logic [3:0] e, a;
    e = {exp_reg[2][1], exp_reg[2][7], exp_reg[3][1], exp_reg[3][0]};
    a = {addr4b_en, nand_page_4k, log_baud_slow, boot_log_off};
    chk(a == e, tag, a, e);
  endtask

  task automatic t_blank();
    reload();
    check_regs("R3 blank register byte");
    check_cfg("R4 blank config");
  endtask

  task automatic t_stall_and_order();
    logic err;
    int early = 0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wr_addr = 5'd0; wr_len = 3'd4; wr_data = 32'h12A23456; wr_req = 1'b1;
    while (!load_done) begin
      @(negedge clk);
      if (wr_ack && !load_done) early++;
    end
    chk(early == 0, "R8 ack during load", early, 0);
    wr_req = 1'b0;
    do_write(5'd0, 3'd4, 32'h12A23456, err);
    chk(err == 1'b0, "R9 legal write error", {31'b0, err}, 0);
    reg_sel = 5'd2;
    #1;
    chk(reg_byte == 8'h00, "R10 register before reload", reg_byte, 0);
    chk(!addr4b_en && !nand_page_4k, "R10 config before reload",
        {30'b0, addr4b_en, nand_page_4k}, 0);
    reload();
    check_regs("R6 little-endian bytes");
    check_cfg("R4 decoded config");
  endtask

  task automatic t_reject_and_err();
    logic err;
    do_write(5'd5, 3'd4, 32'hFFFFFFFF, err);
    chk(err == 1'b1, "R5 misaligned rejected", {31'b0, err}, 1);
    do_write(5'd8, 3'd2, 32'h0000FFFF, err);
    chk(err == 1'b1, "R9 error stays set", {31'b0, err}, 1);
    do_write(5'd8, 3'd4, 32'h00000001, err);
    chk(err == 1'b0, "R9 error cleared by legal write", {31'b0, err}, 0);
    reload();
    check_regs("R5 rejected writes leave fuses");
  endtask

  task automatic t_fuse_semantics();
    logic err;
    do_write(5'd0, 3'd4, 32'h00000000, err);
    do_write(5'd0, 3'd4, 32'h01000001, err);
    do_write(5'd28, 3'd4, 32'h80000000, err);
    reload();
    check_regs("R7 bits only accumulate");
    check_cfg("R4 boot log off decode");
    reload();
    check_regs("R11 fuses persist across reset");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) exp_reg[i] = 8'h00;
    t_blank();
    t_stall_and_order();
    t_reject_and_err();
    t_fuse_semantics();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule